// File: doc/BRIEF.md
# Split Unaligned Load Request Tracker

This block accepts one load at a time and turns it into data cache requests. A load whose bytes all lie within one alignment line goes out as one request. A load that crosses a line boundary goes out as two fragments. The low fragment covers the bytes up to the end of the first line and is sent first. The high fragment starts at the base of the next line and is sent in the following cycle. Each returning fragment is written into its own byte lanes of a local assembly buffer. A small counter tracks how many fragments are still owed. When that counter drains, the tracker raises a one-cycle writeback that carries the load-queue slot and the assembled bytes.

The cache grants or rejects each fragment in the cycle it is presented. The two possible rejections are handled differently:

- If the cache rejects the first fragment, the whole load is dropped and a retry request names the issuing thread.
- If the cache rejects only the second fragment, the count is reduced for the dropped part and a retry is raised. The low fragment then finishes normally.

Load-locked accesses always go out whole. Only one load is tracked at a time, and the input is held off until it finishes or is dropped.

Top module: `unaligned_load_tracker`

## Requirements
- R1: An access whose offset within the line plus its size does not exceed the line size is issued as one request with the load's own address and size and fragment flag 0. It completes after that one response.
- R2: A crossing access is issued as a low request first. The low request has the load's address and size (line size minus offset). In the next cycle a high request follows, with fragment flag 1, the next line's base address, and the remaining size.
- R3: A response with fragment flag 0 fills buffer bytes starting at byte 0. A response with fragment flag 1 fills bytes starting at the low fragment's size. Only the fragment's own size is written, taken from the response's lowest bytes. Every other buffer byte reads as zero for that load.
- R4: Writeback pulses for exactly one cycle, one cycle after the last owed response, with the load's queue index. It never fires while a fragment is still owed, whatever order the responses come back in.
- R5: A rejected first fragment abandons the load. On the next cycle a one-cycle retry carries the thread id. No high request and no writeback follow, and the input is ready again.
- R6: If the high fragment is rejected after the low one was accepted, a one-cycle retry follows. The low response then alone completes the load, and the high byte lanes stay zero.
- R7: A load-locked access is issued as one request of its full size even if it crosses a line.
- R8: At most one fragment is presented and accepted per cycle, and a cache request is only presented while the input is not ready.
- R9: While a load is in flight the input is not ready. A request offered then is neither issued nor reflected in any later writeback.
- R10: After reset the input is ready and no cache request, writeback or retry is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Tracker idle, request taken when valid |
| req_lq_idx | input | LQ_W | Load-queue slot of the load |
| req_tid | input | TID_W | Issuing thread |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Size in bytes, 1 to MAX_BYTES |
| req_locked | input | 1 | Load-locked access, never split |
| cache_req_valid | output | 1 | Fragment presented to the cache |
| cache_req_grant | input | 1 | Cache accepts the presented fragment this cycle |
| cache_req_addr | output | ADDR_W | Fragment address |
| cache_req_size | output | SIZE_W | Fragment size in bytes |
| cache_req_frag | output | 1 | 0 low or whole, 1 high |
| rsp_valid | input | 1 | Fragment response |
| rsp_frag | input | 1 | Which fragment returned |
| rsp_data | input | 8*MAX_BYTES | Fragment bytes, starting at byte 0 |
| wb_valid | output | 1 | Load complete, one-cycle pulse |
| wb_lq_idx | output | LQ_W | Slot of the completed load |
| wb_data | output | 8*MAX_BYTES | Assembled load bytes |
| retry_valid | output | 1 | Retry request, one-cycle pulse |
| retry_tid | output | TID_W | Thread to retry |

## Verification
The assertions assume that the cache returns at most one response per cycle. They also assume it returns one only for a fragment it granted, never in the cycle that fragment is granted, and never twice for the same fragment. They further assume every request size lies between 1 and the buffer width. The directed stimulus drives responses only after the fragment's grant cycle and only for granted fragments. It uses sizes of 1 to 8 bytes and never answers a rejected fragment, so the no-underflow and counter-range checks stay within those assumptions.

// File: rtl/ult_pkg.sv
// Shared types for the unaligned load tracker.
// Assumes nothing beyond being compiled before the modules that import it.
package ult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_WAIT = 2'd3
    } ult_state_e;

    localparam logic FRAG_LO = 1'b0;
    localparam logic FRAG_HI = 1'b1;
endpackage

// File: rtl/ult_splitter.sv
// Combinational line-crossing splitter.
// Works out whether a load crosses a LINE_BYTES boundary and, if so, the
// address and size of both fragments. Locked loads are never split.
// Assumes MAX_BYTES <= LINE_BYTES, both powers of two, size in 1..MAX_BYTES.
module ult_splitter #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 8,
    localparam int LINE_W    = $clog2(LINE_BYTES),
    localparam int SIZE_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              locked_i,
    output logic              split_o,
    output logic [SIZE_W-1:0] lo_size_o,
    output logic [ADDR_W-1:0] hi_addr_o,
    output logic [SIZE_W-1:0] hi_size_o
);
    localparam int SPAN_W = LINE_W + 2;
    localparam int TAG_W  = ADDR_W - LINE_W;

    logic [SPAN_W-1:0] off_w;
    logic [SPAN_W-1:0] span_w;
    logic [SPAN_W-1:0] lo_full;
    logic [TAG_W-1:0]  next_tag;

    // Decide crossing and size each fragment.
    always_comb begin
        off_w     = SPAN_W'(addr_i[LINE_W-1:0]);
        span_w    = off_w + SPAN_W'(size_i);
        lo_full   = SPAN_W'(LINE_BYTES) - off_w;
        split_o   = !locked_i && (span_w > SPAN_W'(LINE_BYTES));
        lo_size_o = split_o ? lo_full[SIZE_W-1:0] : size_i;
        hi_size_o = size_i - lo_size_o;
        next_tag  = addr_i[ADDR_W-1:LINE_W] + TAG_W'(1);
        hi_addr_o = {next_tag, {LINE_W{1'b0}}};
    end
endmodule

// File: rtl/ult_frag_counter.sv
// Outstanding-fragment counter.
// Loaded with 1 or 2 when the first fragment is accepted, then reduced by
// the number of fragments that returned or were dropped in a cycle.
// Assumes a load never coincides with a decrement and decrements never
// exceed the current count.
module ult_frag_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       load_two_i,
    input  logic [1:0] dec_i,
    output logic [1:0] cnt_o,
    output logic       drained_o
);
    logic [1:0] cnt_q;

    // Hold the count of owed fragments.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= 2'd0;
        else if (load_i)
            cnt_q <= load_two_i ? 2'd2 : 2'd1;
        else
            cnt_q <= cnt_q - dec_i;
    end

    assign cnt_o     = cnt_q;
    assign drained_o = (cnt_q != 2'd0) && (dec_i == cnt_q);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |-> (dec_i <= cnt_q));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 2'd2);

    // R8
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (cnt_q == 2'd0));
endmodule

// File: rtl/ult_load_buffer.sv
// Byte-lane assembly buffer for one load.
// Low or whole fragments land from byte 0; high fragments land from the low
// fragment's size. Only the fragment's own bytes are written; the buffer is
// cleared when a new load is accepted.
// Assumes lo_size_i + hi_size_i <= MAX_BYTES.
module ult_load_buffer #(
    parameter int MAX_BYTES = 8,
    localparam int SIZE_W   = $clog2(MAX_BYTES + 1),
    localparam int BUF_W    = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic              frag_i,
    input  logic [SIZE_W-1:0] lo_size_i,
    input  logic [SIZE_W-1:0] hi_size_i,
    input  logic [BUF_W-1:0]  data_i,
    output logic [BUF_W-1:0]  data_o
);
    logic [BUF_W-1:0]     placed;
    logic [MAX_BYTES-1:0] lane_we;
    logic [7:0]           lane_q [MAX_BYTES];

    // Shift the fragment to its lanes and pick the lanes it covers.
    always_comb begin
        placed = frag_i ? (data_i << {lo_size_i, 3'b000}) : data_i;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (frag_i)
                lane_we[i] = wr_i && (i >= int'(lo_size_i))
                             && (i < int'(lo_size_i) + int'(hi_size_i));
            else
                lane_we[i] = wr_i && (i < int'(lo_size_i));
        end
    end

    // Store the covered lanes, clearing all lanes for a new load.
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (!rst_n || clear_i)
                lane_q[i] <= 8'h00;
            else if (lane_we[i])
                lane_q[i] <= placed[i*8 +: 8];
        end
    end

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        assign data_o[g*8 +: 8] = lane_q[g];
    end

    // R3
    lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (data_o == '0));
endmodule

// File: rtl/unaligned_load_tracker.sv
// Split unaligned load request tracker (top).
// Takes one load, issues it as one or two cache fragments, assembles the
// returned bytes, and pulses writeback once all owed fragments are back.
// Rejection of the first fragment abandons the load; rejection of the
// second only drops that fragment. Both raise a retry for the thread.
// Assumes responses come only for granted fragments, never in their grant
// cycle, at most one per cycle.
module unaligned_load_tracker
    import ult_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_BYTES  = 8,
    parameter int LQ_W       = 5,
    parameter int TID_W      = 2,
    localparam int SIZE_W    = $clog2(MAX_BYTES + 1),
    localparam int BUF_W     = 8 * MAX_BYTES,
    localparam int LINE_W    = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LQ_W-1:0]   req_lq_idx,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_locked,
    output logic              cache_req_valid,
    input  logic              cache_req_grant,
    output logic [ADDR_W-1:0] cache_req_addr,
    output logic [SIZE_W-1:0] cache_req_size,
    output logic              cache_req_frag,
    input  logic              rsp_valid,
    input  logic              rsp_frag,
    input  logic [BUF_W-1:0]  rsp_data,
    output logic              wb_valid,
    output logic [LQ_W-1:0]   wb_lq_idx,
    output logic [BUF_W-1:0]  wb_data,
    output logic              retry_valid,
    output logic [TID_W-1:0]  retry_tid
);
    ult_state_e st_q, st_d;

    logic              split_c;
    logic [SIZE_W-1:0] lo_size_c, hi_size_c;
    logic [ADDR_W-1:0] hi_addr_c;

    logic              split_q, locked_q;
    logic [ADDR_W-1:0] lo_addr_q, hi_addr_q;
    logic [SIZE_W-1:0] lo_size_q, hi_size_q;
    logic [LQ_W-1:0]   lq_q;
    logic [TID_W-1:0]  tid_q;

    logic       accept, lo_ok, lo_rej, hi_ok, hi_rej, finish;
    logic [1:0] dec_amt;
    logic [1:0] owed;

    ult_splitter #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
    ) i_split (
        .addr_i(req_addr), .size_i(req_size), .locked_i(req_locked),
        .split_o(split_c), .lo_size_o(lo_size_c),
        .hi_addr_o(hi_addr_c), .hi_size_o(hi_size_c)
    );

    // Handshake and per-fragment outcome decode.
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        accept    = req_valid && req_ready;
        lo_ok     = (st_q == ST_LO) &&  cache_req_grant;
        lo_rej    = (st_q == ST_LO) && !cache_req_grant;
        hi_ok     = (st_q == ST_HI) &&  cache_req_grant;
        hi_rej    = (st_q == ST_HI) && !cache_req_grant;
        dec_amt   = 2'(rsp_valid) + 2'(hi_rej);
    end

    ult_frag_counter i_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_i(lo_ok), .load_two_i(split_q), .dec_i(dec_amt),
        .cnt_o(owed), .drained_o(finish)
    );

    ult_load_buffer #(.MAX_BYTES(MAX_BYTES)) i_buf (
        .clk(clk), .rst_n(rst_n), .clear_i(accept),
        .wr_i(rsp_valid), .frag_i(rsp_frag),
        .lo_size_i(lo_size_q), .hi_size_i(hi_size_q),
        .data_i(rsp_data), .data_o(wb_data)
    );

    // Capture the accepted load and its fragment plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q   <= 1'b0;
            locked_q  <= 1'b0;
            lo_addr_q <= '0;
            hi_addr_q <= '0;
            lo_size_q <= '0;
            hi_size_q <= '0;
            lq_q      <= '0;
            tid_q     <= '0;
        end else if (accept) begin
            split_q   <= split_c;
            locked_q  <= req_locked;
            lo_addr_q <= req_addr;
            hi_addr_q <= hi_addr_c;
            lo_size_q <= lo_size_c;
            hi_size_q <= hi_size_c;
            lq_q      <= req_lq_idx;
            tid_q     <= req_tid;
        end
    end

    // Next-state sequencing of issue and wait.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_LO;
            ST_LO:   st_d = lo_ok ? (split_q ? ST_HI : ST_WAIT) : ST_IDLE;
            ST_HI:   st_d = finish ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (finish) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Present the current fragment to the cache.
    always_comb begin
        cache_req_valid = (st_q == ST_LO) || (st_q == ST_HI);
        cache_req_frag  = (st_q == ST_HI) ? FRAG_HI : FRAG_LO;
        cache_req_addr  = (st_q == ST_HI) ? hi_addr_q : lo_addr_q;
        cache_req_size  = (st_q == ST_HI) ? hi_size_q : lo_size_q;
    end

    // Registered writeback and retry pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid    <= 1'b0;
            wb_lq_idx   <= '0;
            retry_valid <= 1'b0;
            retry_tid   <= '0;
        end else begin
            wb_valid    <= finish;
            retry_valid <= lo_rej || hi_rej;
            if (finish)            wb_lq_idx <= lq_q;
            if (lo_rej || hi_rej)  retry_tid <= tid_q;
        end
    end

    // R4
    wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R5
    lo_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rej |=> (retry_valid && !wb_valid && req_ready && !cache_req_valid));

    // R2
    hi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_ok && split_q) |=> (cache_req_valid && cache_req_frag
                                && (cache_req_addr[LINE_W-1:0] == '0)));

    // R7
    locked_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req_valid && locked_q) |-> !cache_req_frag);

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid |-> !req_ready);

    // R6
    hi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rej |=> (retry_valid && !cache_req_valid));

    // R4
    rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (owed != 2'd0));
endmodule

// File: tb/test_unaligned_load_tracker.sv
module test_unaligned_load_tracker;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 4;
    localparam int LQ_W   = 5;
    localparam int TID_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LQ_W-1:0]   req_lq_idx = '0;
    logic [TID_W-1:0]  req_tid = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              req_locked = 1'b0;
    logic              cache_req_valid;
    logic              cache_req_grant = 1'b0;
    logic [ADDR_W-1:0] cache_req_addr;
    logic [SIZE_W-1:0] cache_req_size;
    logic              cache_req_frag;
    logic              rsp_valid = 1'b0;
    logic              rsp_frag = 1'b0;
    logic [63:0]       rsp_data = '0;
    logic              wb_valid;
    logic [LQ_W-1:0]   wb_lq_idx;
    logic [63:0]       wb_data;
    logic              retry_valid;
    logic [TID_W-1:0]  retry_tid;

    int n_checks = 0;
    int n_fails  = 0;
    bit run_done = 1'b0;

    always #4 clk = ~clk;

    unaligned_load_tracker i_unaligned_load_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_lq_idx(req_lq_idx), .req_tid(req_tid),
        .req_addr(req_addr), .req_size(req_size), .req_locked(req_locked),
        .cache_req_valid(cache_req_valid), .cache_req_grant(cache_req_grant),
        .cache_req_addr(cache_req_addr), .cache_req_size(cache_req_size),
        .cache_req_frag(cache_req_frag),
        .rsp_valid(rsp_valid), .rsp_frag(rsp_frag), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_lq_idx(wb_lq_idx), .wb_data(wb_data),
        .retry_valid(retry_valid), .retry_tid(retry_tid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_req(input int lq, input int tid, input logic [31:0] a,
                            input int sz, input bit lk);
        req_valid  = 1'b1;
        req_lq_idx = LQ_W'(lq);
        req_tid    = TID_W'(tid);
        req_addr   = a;
        req_size   = SIZE_W'(sz);
        req_locked = lk;
        tick();
        req_valid  = 1'b0;
        req_locked = 1'b0;
    endtask

    task automatic expect_req(input string tag, input logic [31:0] a, input int sz, input bit fr);
        chk({tag, " req valid"}, 64'(cache_req_valid), 64'd1);
        chk({tag, " req addr"}, 64'(cache_req_addr), 64'(a));
        chk({tag, " req size"}, 64'(cache_req_size), 64'(sz));
        chk({tag, " req frag"}, 64'(cache_req_frag), 64'(fr));
    endtask

    task automatic give_grant(input bit g);
        cache_req_grant = g;
        tick();
        cache_req_grant = 1'b0;
    endtask

    task automatic respond(input bit fr, input logic [63:0] d);
        rsp_valid = 1'b1;
        rsp_frag  = fr;
        rsp_data  = d;
        tick();
        rsp_valid = 1'b0;
        rsp_data  = '0;
    endtask

    task automatic expect_wb(input string tag, input int lq, input logic [63:0] d);
        chk({tag, " wb valid"}, 64'(wb_valid), 64'd1);
        chk({tag, " wb lq"}, 64'(wb_lq_idx), 64'(lq));
        chk({tag, " wb data"}, wb_data, d);
        tick();
        chk({tag, " wb pulse ends"}, 64'(wb_valid), 64'd0);
        chk({tag, " ready again"}, 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R10 ready", 64'(req_ready), 64'd1);
        chk("R10 cache idle", 64'(cache_req_valid), 64'd0);
        chk("R10 no wb", 64'(wb_valid), 64'd0);
        chk("R10 no retry", 64'(retry_valid), 64'd0);
    endtask

    task automatic t_whole();
        send_req(3, 1, 32'h100, 8, 1'b0);
        expect_req("R1 aligned", 32'h100, 8, 1'b0);
        chk("R9 busy", 64'(req_ready), 64'd0);
        give_grant(1'b1);
        chk("R1 single request", 64'(cache_req_valid), 64'd0);
        chk("R4 no early wb", 64'(wb_valid), 64'd0);
        respond(1'b0, 64'h0123_4567_89AB_CDEF);
        expect_wb("R1 aligned", 3, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_edge_fit();
        send_req(5, 0, 32'h20C, 4, 1'b0);
        expect_req("R1 boundary fit", 32'h20C, 4, 1'b0);
        give_grant(1'b1);
        chk("R1 boundary single", 64'(cache_req_valid), 64'd0);
        respond(1'b0, 64'h9988_7766_A1B2_C3D4);
        expect_wb("R3 size-bounded", 5, 64'h0000_0000_A1B2_C3D4);
    endtask

    task automatic t_split_inorder();
        send_req(7, 1, 32'h10E, 8, 1'b0);
        expect_req("R2 low", 32'h10E, 2, 1'b0);
        give_grant(1'b1);
        expect_req("R2 high R8 next cycle", 32'h110, 6, 1'b1);
        give_grant(1'b1);
        chk("R8 nothing after high", 64'(cache_req_valid), 64'd0);
        respond(1'b0, 64'h1111_1111_1111_BBAA);
        chk("R4 wait for high", 64'(wb_valid), 64'd0);
        respond(1'b1, 64'hFFFF_6655_4433_2211);
        expect_wb("R3 split", 7, 64'h6655_4433_2211_BBAA);
    endtask

    task automatic t_split_reorder();
        send_req(8, 2, 32'h30D, 4, 1'b0);
        expect_req("R2 low 3B", 32'h30D, 3, 1'b0);
        give_grant(1'b1);
        expect_req("R2 high 1B", 32'h310, 1, 1'b1);
        give_grant(1'b1);
        respond(1'b1, 64'h7777_7777_7777_77EE);
        chk("R4 high first no wb", 64'(wb_valid), 64'd0);
        respond(1'b0, 64'h5555_5555_55CC_BBAA);
        expect_wb("R3 reorder", 8, 64'h0000_0000_EECC_BBAA);
    endtask

    task automatic t_locked();
        send_req(12, 0, 32'h10E, 8, 1'b1);
        expect_req("R7 locked whole", 32'h10E, 8, 1'b0);
        give_grant(1'b1);
        chk("R7 no high", 64'(cache_req_valid), 64'd0);
        respond(1'b0, 64'hDEAD_BEEF_CAFE_F00D);
        expect_wb("R7 locked", 12, 64'hDEAD_BEEF_CAFE_F00D);
    endtask

    task automatic t_lo_reject();
        send_req(9, 2, 32'h40E, 8, 1'b0);
        expect_req("R5 low", 32'h40E, 2, 1'b0);
        give_grant(1'b0);
        chk("R5 retry", 64'(retry_valid), 64'd1);
        chk("R5 retry tid", 64'(retry_tid), 64'd2);
        chk("R5 no high", 64'(cache_req_valid), 64'd0);
        chk("R5 ready", 64'(req_ready), 64'd1);
        chk("R5 no wb", 64'(wb_valid), 64'd0);
        tick();
        chk("R5 retry pulse", 64'(retry_valid), 64'd0);
        chk("R5 still no wb", 64'(wb_valid), 64'd0);
        chk("R5 still idle", 64'(cache_req_valid), 64'd0);
    endtask

    task automatic t_hi_reject();
        send_req(11, 3, 32'h50E, 8, 1'b0);
        expect_req("R6 low", 32'h50E, 2, 1'b0);
        give_grant(1'b1);
        expect_req("R6 high", 32'h510, 6, 1'b1);
        give_grant(1'b0);
        chk("R6 retry", 64'(retry_valid), 64'd1);
        chk("R6 retry tid", 64'(retry_tid), 64'd3);
        chk("R6 still busy", 64'(req_ready), 64'd0);
        chk("R6 no wb yet", 64'(wb_valid), 64'd0);
        respond(1'b0, 64'h1234_5678_9ABC_BBAA);
        expect_wb("R6 low only", 11, 64'h0000_0000_0000_BBAA);
    endtask

    task automatic t_busy_ignore();
        send_req(4, 1, 32'h600, 8, 1'b0);
        expect_req("R9 first", 32'h600, 8, 1'b0);
        give_grant(1'b1);
        req_valid  = 1'b1;
        req_lq_idx = LQ_W'(20);
        req_addr   = 32'h700;
        req_size   = SIZE_W'(4);
        chk("R9 not ready", 64'(req_ready), 64'd0);
        tick();
        req_valid = 1'b0;
        respond(1'b0, 64'hAAAA_BBBB_CCCC_DDDD);
        expect_wb("R9 original", 4, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R9 ignored not issued", 64'(cache_req_valid), 64'd0);
    endtask

    initial begin
        t_reset();
        t_whole();
        t_edge_fit();
        t_split_inorder();
        t_split_reorder();
        t_locked();
        t_lo_reject();
        t_hi_reject();
        t_busy_ignore();
        run_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule